// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog for a system clock domain. Software programs it over a simple register bus that completes a write or a read in one cycle. A control register holds two enables, an 8-bit prescaler and a 2-bit divider select. The input clock is divided first by the prescaler and then by a power of two. Each divided tick lowers a 16-bit counter by one. Software restarts the timeout by writing a new value straight into the count register.

When the count runs out on a tick, the counter is loaded from a reload register. If the reset enable is also set, the block drives a reset request pulse of fixed length for the chip's reset logic. To stop the watchdog, software clears the timer enable. To turn it into a plain periodic counter, software clears only the reset enable.

Top module: `wdt_core`

## Requirements
- R1: After reset, the control register reads 0x0000, the reload and count registers read 0x8000, and `rst_req_o` is low.
- R2: Register offsets are 0x0 for control, 0x4 for reload and 0x8 for count, and any other offset reads 0. The control layout is: bit 0 timer enable, bit 1 reset enable, bits 3:2 divider select, bits 15:8 prescaler. Bits 7:4 read as 0.
- R3: While the timer enable is set, a divided tick occurs every (prescaler+1)·2^(4+select) clock cycles. The first tick lands that many cycles after the write that sets the enable. Each tick lowers the count by one.
- R4: A write to the count register loads the counter on that edge. It always takes effect, and it wins over a tick that falls on the same edge.
- R5: A tick that finds the count at 1 or 0 is an expiry. On an expiry the counter is loaded from the reload register.
- R6: On an expiry with the reset enable set, `rst_req_o` goes high from the next cycle and stays high for exactly 128 clock cycles.
- R7: With the reset enable clear, expiries still reload the counter, but `rst_req_o` stays low.
- R8: While the timer enable is clear, the count does not change and no reset request is made, whatever the reset enable holds.
- R9: A write to the reload register is ignored while the timer enable is set, and accepted while it is clear.
- R10: Writing a count of 1 and then setting both enables raises `rst_req_o` within one divided tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The assertions assume that the bus carries at most one write per cycle and that software changes the prescaler or divider select only while the timer is stopped. A select changed in mid-count gives one shortened tick, which the assertions do not model. The stimulus respects this: every divide setting is written with the timer disabled and then enabled by the same write. The reload value used in the pulse test is large enough that no second expiry falls inside a 128-cycle pulse, so each pulse can be timed on its own.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W      = 16;
  localparam int PSC_W      = 8;
  localparam int SEL_W      = 2;
  localparam int BASE_SHIFT = 4;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 4;
  localparam int MAX_SEL    = (1 << SEL_W) - 1;
  localparam int POW_W      = BASE_SHIFT + MAX_SEL;
  localparam int PSC_LSB    = 8;
  localparam int SEL_LSB    = 2;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 4'h8;
  localparam logic [CNT_W-1:0]  CNT_INIT   = 16'h8000;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic [SEL_W-1:0] sel;
    logic             rst_en;
    logic             run_en;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0] = c.run_en;
    w[1] = c.rst_en;
    w[SEL_LSB +: SEL_W] = c.sel;
    w[PSC_LSB +: PSC_W] = c.psc;
    return w;
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [DATA_W-1:0] w);
    ctrl_t c;
    c.run_en = w[0];
    c.rst_en = w[1];
    c.sel    = w[SEL_LSB +: SEL_W];
    c.psc    = w[PSC_LSB +: PSC_W];
    return c;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              cnt_we_o,
  output logic [CNT_W-1:0]  cnt_wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             ctrl_we, reload_we;

  assign ctrl_we   = wr_i && (addr_i == OFS_CTRL);
  // reload is frozen while the timer runs
  assign reload_we = wr_i && (addr_i == OFS_RELOAD) && !ctrl_q.run_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= CNT_INIT;
    end else begin
      if (ctrl_we)   ctrl_q   <= ctrl_unpack(wdata_i);
      if (reload_we) reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    case (addr_i)
      OFS_CTRL:   rdata_o = ctrl_pack(ctrl_q);
      OFS_RELOAD: rdata_o = DATA_W'(reload_q);
      OFS_COUNT:  rdata_o = DATA_W'(cnt_i);
      default:    rdata_o = '0;
    endcase
  end

  assign ctrl_o      = ctrl_q;
  assign reload_o    = reload_q;
  assign cnt_we_o    = wr_i && (addr_i == OFS_COUNT);
  assign cnt_wdata_o = wdata_i[CNT_W-1:0];

  p_reload_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_RELOAD && ctrl_q.run_en) |=> $stable(reload_q));

  p_reload_taken_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_RELOAD && !ctrl_q.run_en) |=> reload_q == $past(wdata_i[CNT_W-1:0]));
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_en_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] psc_cnt;
  logic [POW_W-1:0] pow_cnt;
  logic [POW_W-1:0] pow_lim;
  logic             pre_hit, pow_hit;

  // 2^(BASE_SHIFT+sel)-1 as a right-shifted all-ones mask
  assign pow_lim = {POW_W{1'b1}} >> (MAX_SEL - int'(sel_i));
  assign pre_hit = psc_cnt >= psc_i;
  assign pow_hit = pow_cnt >= pow_lim;
  assign tick_o  = run_en_i && pre_hit && pow_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_cnt <= '0;
      pow_cnt <= '0;
    end else if (!run_en_i) begin
      psc_cnt <= '0;
      pow_cnt <= '0;
    end else if (pre_hit) begin
      psc_cnt <= '0;
      pow_cnt <= pow_hit ? '0 : pow_cnt + 1'b1;
    end else begin
      psc_cnt <= psc_cnt + 1'b1;
    end
  end

  p_tick_spaced_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_en_i,
  input  logic             rst_en_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rst_req_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    pulse_q;
  logic             expire;

  // a kick on the same edge cancels the expiry
  assign expire = tick_i && !cnt_we_i && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= CNT_INIT;
    else if (cnt_we_i) cnt_q <= cnt_wdata_i;
    else if (expire)   cnt_q <= reload_i;
    else if (tick_i)   cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pulse_q <= '0;
    else if (expire && rst_en_i) pulse_q <= PW'(PULSE_LEN);
    else if (pulse_q != '0)      pulse_q <= pulse_q - 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign rst_req_o = pulse_q != '0;

  p_kick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_q == $past(cnt_wdata_i));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_we_i && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - 1'b1);

  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_we_i && cnt_q <= CNT_W'(1)) |=> cnt_q == $past(reload_i));

  p_pulse_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_we_i && cnt_q <= CNT_W'(1) && rst_en_i) |=> rst_req_o);

  p_no_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(rst_en_i && run_en_i));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en_i && !cnt_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, cnt, cnt_wdata;
  logic             cnt_we, tick;

  wdt_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .cnt_i       (cnt),
    .ctrl_o      (ctrl),
    .reload_o    (reload),
    .cnt_we_o    (cnt_we),
    .cnt_wdata_o (cnt_wdata),
    .rdata_o     (rdata_o)
  );

  wdt_prescale u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_en_i (ctrl.run_en),
    .psc_i    (ctrl.psc),
    .sel_i    (ctrl.sel),
    .tick_o   (tick)
  );

  wdt_count #(.PULSE_LEN(PULSE_LEN)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .run_en_i    (ctrl.run_en),
    .rst_en_i    (ctrl.rst_en),
    .reload_i    (reload),
    .cnt_we_i    (cnt_we),
    .cnt_wdata_i (cnt_wdata),
    .cnt_o       (cnt),
    .rst_req_o   (rst_req_o)
  );
endmodule

// File: tb/sim_wdt_core.sv
module sim_wdt_core;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        rst_req_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wdt_core u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the following posedge
  task automatic wr_reg(logic [3:0] a, logic [15:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [15:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic wait_e(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, held;
    bit seen;
    wait_e(3);
    rst_ni = 1'b1;
    wait_e(1);

    // R1 reset values
    rd_reg(4'h0, v); chk("R1 ctrl", v, 16'h0000);
    rd_reg(4'h4, v); chk("R1 reload", v, 16'h8000);
    rd_reg(4'h8, v); chk("R1 count", v, 16'h8000);
    chk("R1 rst_req", rst_req_o, 0);
    // R2 unmapped offset and field layout
    rd_reg(4'hC, v); chk("R2 unmapped", v, 16'h0000);
    wr_reg(4'h0, 16'hA5FC);
    rd_reg(4'h0, v); chk("R2 ctrl fields", v, 16'hA50C);
    wr_reg(4'h0, 16'h0000);

    // R9 reload accepted while stopped
    wr_reg(4'h4, 16'h0010);
    rd_reg(4'h4, v); chk("R9 reload open", v, 16'h0010);

    // R3 divider sweep
    for (int p = 0; p < 3; p++) begin
      for (int s = 0; s < 4; s++) begin
        int d;
        d = (p + 1) << (4 + s);
        wr_reg(4'h8, 16'd1000);
        wr_reg(4'h0, 16'((p << 8) | (s << 2) | 1));
        wait_e(3 * d - 1);
        rd_reg(4'h8, v); chk($sformatf("R3 p%0d s%0d before", p, s), v, 16'd998);
        wait_e(1);
        rd_reg(4'h8, v); chk($sformatf("R3 p%0d s%0d edge", p, s), v, 16'd997);
        chk("R3 no req", rst_req_o, 0);
        wr_reg(4'h0, 16'h0000);
      end
    end

    // R5 R7 expiry reload without reset
    wr_reg(4'h4, 16'd3);
    wr_reg(4'h8, 16'd2);
    wr_reg(4'h0, 16'h0001);
    wait_e(15); rd_reg(4'h8, v); chk("R3 first tick pending", v, 16'd2);
    wait_e(1);  rd_reg(4'h8, v); chk("R3 first tick", v, 16'd1);
    wait_e(15); rd_reg(4'h8, v); chk("R5 before expiry", v, 16'd1);
    wait_e(1);  rd_reg(4'h8, v); chk("R5 reload", v, 16'd3);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      wait_e(1);
      if (rst_req_o) seen = 1;
    end
    chk("R7 no reset request", seen, 0);
    wr_reg(4'h0, 16'h0000);

    // R6 R10 reset pulse
    wr_reg(4'h4, 16'd100);
    wr_reg(4'h8, 16'd1);
    wr_reg(4'h0, 16'h0103);
    wait_e(31); chk("R10 not yet", rst_req_o, 0);
    wait_e(1);  chk("R10 within one tick", rst_req_o, 1);
    rd_reg(4'h8, v); chk("R5 reload at reset", v, 16'd100);
    wait_e(127); chk("R6 last pulse cycle", rst_req_o, 1);
    wait_e(1);   chk("R6 pulse ends", rst_req_o, 0);
    wr_reg(4'h0, 16'h0000);

    // R8 hold while stopped
    rd_reg(4'h8, held); chk("R8 count at stop", held, 16'd96);
    wait_e(400);
    rd_reg(4'h8, v); chk("R8 held", v, held);

    // R9 reload frozen while running
    wr_reg(4'h0, 16'h0001);
    wr_reg(4'h4, 16'h1234);
    rd_reg(4'h4, v); chk("R9 reload locked", v, 16'd100);
    wr_reg(4'h0, 16'h0000);
    wr_reg(4'h4, 16'h1234);
    rd_reg(4'h4, v); chk("R9 reload after stop", v, 16'h1234);

    // R4 kick on a tick edge
    wr_reg(4'h8, 16'd50);
    wr_reg(4'h0, 16'h0001);
    wait_e(15);
    wr_reg(4'h8, 16'h0777);
    rd_reg(4'h8, v); chk("R4 kick wins", v, 16'h0777);
    wait_e(15); rd_reg(4'h8, v); chk("R4 after kick", v, 16'h0777);
    wait_e(1);  rd_reg(4'h8, v); chk("R4 next tick", v, 16'h0776);
    wr_reg(4'h0, 16'h0000);

    // R8 reset enable alone does nothing
    wr_reg(4'h8, 16'd1);
    wr_reg(4'h0, 16'h0002);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      wait_e(1);
      if (rst_req_o) seen = 1;
    end
    chk("R8 no request when stopped", seen, 0);
    rd_reg(4'h8, v); chk("R8 count kept", v, 16'd1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule